// File: doc/BRIEF.md
# Syncpoint Threshold Interrupt Controller

The block keeps a parameterised array of 32-bit syncpoint counters, each paired with a programmable threshold. Counters advance by one when an increment request names their index. After an increment, and also after a threshold write, the block compares the counter with the threshold while allowing for wrap. It does this by taking the signed 32-bit difference (counter minus threshold). When that difference is zero or positive and the syncpoint is enabled, a pending bit is latched for the syncpoint.

Pending bits and enable bits are grouped 32 syncpoints per word. Syncpoint n sits in group n/32 at bit n%32. Software changes enables only through separate set and clear words, and it clears pending bits by writing ones. Each syncpoint also has a route register that chooses one of up to eight interrupt lines. Every line is the OR of the enabled, pending syncpoints routed to it.

A flat word-addressed bus writes registers on `bus_we_i`. Read data is combinational from the address. The top two address bits pick a region: 0 for thresholds, 1 for routes, 2 for group words. The low `IDX_W` bits carry the syncpoint index. In region 2, bits `[IDX_W-1:2]` are the group and bits `[1:0]` pick the word: 0 is enable-set, 1 is enable-clear, 2 is pending status. Both enable words read back the enable mask. Word 3 and region 3 read zero.

Top module: `syncpt_intr_ctrl`

## Requirements
- R1: After reset, every threshold, route, enable and pending bit reads zero, and all interrupt lines are low.
- R2: Writing address `{2'b00, n}` stores a 32-bit threshold for syncpoint n. Reading the same address returns it.
- R3: An increment of syncpoint n raises its counter by one. The pending bit is set on that clock edge when the counter is enabled and the signed 32-bit value (new counter minus threshold) is at least zero, including across wrap.
- R4: A threshold write performs the same comparison against the current counter and sets the pending bit under the same rule.
- R5: Writing a mask to enable-set (word 0) sets the masked enable bits of that group. Writing a mask to enable-clear (word 1) clears them. Other enable bits are left unchanged.
- R6: Writing ones to the status word (word 2) clears those pending bits. Zero bits in the write leave pending bits unchanged.
- R7: A pending bit latches only while its enable bit is set. Clearing the enable keeps an already pending bit.
- R8: Interrupt line k is the OR of (pending AND enable) over the syncpoints whose 3-bit route (address `{2'b01, n}`, data bits [2:0]) equals k. Route values at or above `NUM_LINES` drive no line.
- R9: If an increment event and a status clear hit the same syncpoint in the same cycle, the pending bit ends up set.
- R10: Writing all ones to a group's enable-clear word and then to its status word leaves that group with no enables and no pending bits, without touching other groups.
- R11: Syncpoint n maps to group n/32, bit n%32, in both the enable words and the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inc_valid_i | input | 1 | Increment request valid |
| inc_idx_i | input | IDX_W | Syncpoint to increment |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | NUM_LINES | Interrupt lines |

## Verification
A write or increment presented before a rising edge shows up in state at that edge. A pending bit caused by an increment or a threshold write is therefore readable, and visible on `irq_o`, in the cycle right after the request. Read data and the lines follow the registers combinationally. The bench drives every request at a falling edge and holds it for exactly one cycle. It then samples read data and lines one time step after the next falling edge, half a period clear of the edge that committed the request.

// File: rtl/syncpt_pkg.sv
package syncpt_pkg;
  localparam int unsigned CNT_W     = 32;
  localparam int unsigned GRP_BITS  = 32;
  localparam int unsigned DST_W     = 3;
  localparam int unsigned MAX_LINES = 1 << DST_W;

  localparam logic [1:0] RGN_THR = 2'd0;
  localparam logic [1:0] RGN_DST = 2'd1;
  localparam logic [1:0] RGN_GRP = 2'd2;

  localparam logic [1:0] SUB_EN_SET = 2'd0;
  localparam logic [1:0] SUB_EN_CLR = 2'd1;
  localparam logic [1:0] SUB_STAT   = 2'd2;
endpackage

// File: rtl/syncpt_cell.sv
module syncpt_cell
  import syncpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             thr_we_i,
  input  logic             dst_we_i,
  input  logic [CNT_W-1:0] thr_wdata_i,
  input  logic [DST_W-1:0] dst_wdata_i,
  output logic [CNT_W-1:0] thr_o,
  output logic [DST_W-1:0] dst_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, thr_q, thr_d;
  logic [DST_W-1:0] dst_q;

  assign cnt_d = cnt_q + CNT_W'(inc_i);
  assign thr_d = thr_we_i ? thr_wdata_i : thr_q;
  // wrap-aware: counter at or past threshold
  assign hit_o = (inc_i | thr_we_i) && ($signed(cnt_d - thr_d) >= 0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      thr_q <= '0;
      dst_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      thr_q <= thr_d;
      if (dst_we_i) dst_q <= dst_wdata_i;
    end
  end

  assign thr_o = thr_q;
  assign dst_o = dst_q;

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_thr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_we_i |=> (thr_q == $past(thr_wdata_i)));
endmodule

// File: rtl/syncpt_group.sv
module syncpt_group
  import syncpt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_we_i,
  input  logic                clr_we_i,
  input  logic                st_we_i,
  input  logic [GRP_BITS-1:0] wdata_i,
  input  logic [GRP_BITS-1:0] hit_i,
  output logic [GRP_BITS-1:0] en_o,
  output logic [GRP_BITS-1:0] st_o
);
  logic [GRP_BITS-1:0] en_q, st_q, set_m, clr_m, w1c_m, new_m;

  assign set_m = set_we_i ? wdata_i : '0;
  assign clr_m = clr_we_i ? wdata_i : '0;
  assign w1c_m = st_we_i  ? wdata_i : '0;
  assign new_m = hit_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= (en_q | set_m) & ~clr_m;
      st_q <= (st_q & ~w1c_m) | new_m;  // new events beat clears
    end
  end

  assign en_o = en_q;
  assign st_o = st_q;

  assert_gated_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));
  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we_i |=> ((st_q & $past(wdata_i) & ~$past(hit_i & en_q)) == '0));
  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((st_q & $past(hit_i & en_q)) == $past(hit_i & en_q)));
  assert_en_masks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
endmodule

// File: rtl/syncpt_router.sv
module syncpt_router
  import syncpt_pkg::*;
#(
  parameter int unsigned NUM_SP    = 64,
  parameter int unsigned NUM_LINES = 4
) (
  input  logic [NUM_SP-1:0]            masked_i,
  input  logic [NUM_SP-1:0][DST_W-1:0] dst_i,
  output logic [NUM_LINES-1:0]         irq_o
);
  always_comb begin
    irq_o = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      for (int i = 0; i < NUM_SP; i++) begin
        if (masked_i[i] && dst_i[i] == DST_W'(l)) irq_o[l] = 1'b1;
      end
    end
  end

  always_comb begin
    assert_idle_lines_R8: assert (masked_i != '0 || irq_o == '0);
  end
endmodule

// File: rtl/syncpt_intr_ctrl.sv
module syncpt_intr_ctrl
  import syncpt_pkg::*;
#(
  parameter int unsigned NUM_SP    = 64,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned IDX_W     = $clog2(NUM_SP),
  parameter int unsigned ADDR_W    = IDX_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 inc_valid_i,
  input  logic [IDX_W-1:0]     inc_idx_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int unsigned NGRP  = NUM_SP / GRP_BITS;
  localparam int unsigned GRP_W = IDX_W - 2;

  logic [1:0]       rgn;
  logic [IDX_W-1:0] idx;
  logic [GRP_W-1:0] grp;
  logic [1:0]       sub;

  assign rgn = bus_addr_i[ADDR_W-1 -: 2];
  assign idx = bus_addr_i[IDX_W-1:0];
  assign grp = bus_addr_i[IDX_W-1:2];
  assign sub = bus_addr_i[1:0];

  logic [NUM_SP-1:0][CNT_W-1:0] thr_w;
  logic [NUM_SP-1:0][DST_W-1:0] dst_w;
  logic [NUM_SP-1:0]            hit_w, en_w, st_w;

  for (genvar i = 0; i < NUM_SP; i++) begin : g_cell
    logic sel;
    assign sel = (idx == IDX_W'(i));
    syncpt_cell i_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .inc_i       (inc_valid_i && inc_idx_i == IDX_W'(i)),
      .thr_we_i    (bus_we_i && rgn == RGN_THR && sel),
      .dst_we_i    (bus_we_i && rgn == RGN_DST && sel),
      .thr_wdata_i (bus_wdata_i),
      .dst_wdata_i (bus_wdata_i[DST_W-1:0]),
      .thr_o       (thr_w[i]),
      .dst_o       (dst_w[i]),
      .hit_o       (hit_w[i])
    );
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic gsel;
    assign gsel = bus_we_i && rgn == RGN_GRP && grp == GRP_W'(g);
    syncpt_group i_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_we_i (gsel && sub == SUB_EN_SET),
      .clr_we_i (gsel && sub == SUB_EN_CLR),
      .st_we_i  (gsel && sub == SUB_STAT),
      .wdata_i  (bus_wdata_i),
      .hit_i    (hit_w[g*GRP_BITS +: GRP_BITS]),
      .en_o     (en_w[g*GRP_BITS +: GRP_BITS]),
      .st_o     (st_w[g*GRP_BITS +: GRP_BITS])
    );
  end

  syncpt_router #(.NUM_SP(NUM_SP), .NUM_LINES(NUM_LINES)) i_router (
    .masked_i (st_w & en_w),
    .dst_i    (dst_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (rgn)
      RGN_THR: for (int i = 0; i < NUM_SP; i++)
                 if (idx == IDX_W'(i)) bus_rdata_o = thr_w[i];
      RGN_DST: for (int i = 0; i < NUM_SP; i++)
                 if (idx == IDX_W'(i)) bus_rdata_o = 32'(dst_w[i]);
      RGN_GRP: for (int g = 0; g < NGRP; g++)
                 if (grp == GRP_W'(g)) begin
                   if (sub == SUB_EN_SET || sub == SUB_EN_CLR)
                     bus_rdata_o = en_w[g*GRP_BITS +: GRP_BITS];
                   else if (sub == SUB_STAT)
                     bus_rdata_o = st_w[g*GRP_BITS +: GRP_BITS];
                 end
      default: bus_rdata_o = '0;
    endcase
  end

  initial begin
    assert_geom_R11: assert (NUM_SP % GRP_BITS == 0 && NUM_SP >= GRP_BITS
                             && NUM_LINES >= 1 && NUM_LINES <= MAX_LINES);
  end

  assert_line_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w == '0) |-> (irq_o == '0));
endmodule

// File: tb/test_syncpt_intr_ctrl.sv
module test_syncpt_intr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IN = 2'd2, OP_IQ = 2'd3;
  localparam int NVEC = 62;

  // {req, op, addr, data}; RD/IQ carry the expected value
  localparam logic [45:0] VEC [NVEC] = '{
    {4'd2,  OP_WR, 8'h03, 32'h3},        // R2
    {4'd2,  OP_RD, 8'h03, 32'h3},        // R2
    {4'd5,  OP_WR, 8'h80, 32'h8},        // R5
    {4'd5,  OP_WR, 8'h80, 32'h1},        // R5
    {4'd5,  OP_RD, 8'h80, 32'h9},        // R5
    {4'd5,  OP_WR, 8'h81, 32'h1},        // R5
    {4'd5,  OP_RD, 8'h81, 32'h8},        // R5
    {4'd3,  OP_IN, 8'h03, 32'h0},        // R3
    {4'd3,  OP_RD, 8'h82, 32'h0},        // R3
    {4'd3,  OP_IN, 8'h03, 32'h0},        // R3
    {4'd3,  OP_RD, 8'h82, 32'h0},        // R3
    {4'd3,  OP_IN, 8'h03, 32'h0},        // R3
    {4'd3,  OP_RD, 8'h82, 32'h8},        // R3
    {4'd8,  OP_IQ, 8'h00, 32'h1},        // R8
    {4'd8,  OP_WR, 8'h43, 32'h2},        // R8
    {4'd8,  OP_IQ, 8'h00, 32'h4},        // R8
    {4'd8,  OP_RD, 8'h43, 32'h2},        // R8
    {4'd8,  OP_WR, 8'h43, 32'h6},        // R8
    {4'd8,  OP_IQ, 8'h00, 32'h0},        // R8
    {4'd8,  OP_WR, 8'h43, 32'h1},        // R8
    {4'd8,  OP_IQ, 8'h00, 32'h2},        // R8
    {4'd6,  OP_WR, 8'h82, 32'h0},        // R6
    {4'd6,  OP_RD, 8'h82, 32'h8},        // R6
    {4'd6,  OP_WR, 8'h82, 32'h8},        // R6
    {4'd6,  OP_RD, 8'h82, 32'h0},        // R6
    {4'd6,  OP_IQ, 8'h00, 32'h0},        // R6
    {4'd4,  OP_WR, 8'h03, 32'h2},        // R4
    {4'd4,  OP_RD, 8'h82, 32'h8},        // R4
    {4'd4,  OP_WR, 8'h82, 32'h8},        // R4
    {4'd4,  OP_RD, 8'h82, 32'h0},        // R4
    {4'd4,  OP_WR, 8'h03, 32'hA},        // R4
    {4'd4,  OP_RD, 8'h82, 32'h0},        // R4
    {4'd7,  OP_WR, 8'h81, 32'h8},        // R7
    {4'd7,  OP_WR, 8'h03, 32'h0},        // R7
    {4'd7,  OP_RD, 8'h82, 32'h0},        // R7
    {4'd7,  OP_WR, 8'h80, 32'h8},        // R7
    {4'd7,  OP_WR, 8'h03, 32'h1},        // R7
    {4'd7,  OP_RD, 8'h82, 32'h8},        // R7
    {4'd7,  OP_WR, 8'h81, 32'h8},        // R7
    {4'd7,  OP_RD, 8'h82, 32'h8},        // R7
    {4'd7,  OP_IQ, 8'h00, 32'h0},        // R7
    {4'd11, OP_WR, 8'h84, 32'h20},       // R11
    {4'd11, OP_IN, 8'h25, 32'h0},        // R11
    {4'd11, OP_RD, 8'h86, 32'h20},       // R11
    {4'd11, OP_RD, 8'h82, 32'h8},        // R11
    {4'd11, OP_IQ, 8'h00, 32'h1},        // R11
    {4'd3,  OP_WR, 8'h28, 32'h80000001}, // R3
    {4'd3,  OP_WR, 8'h84, 32'h100},      // R3
    {4'd3,  OP_RD, 8'h84, 32'h120},      // R3
    {4'd3,  OP_IN, 8'h28, 32'h0},        // R3
    {4'd3,  OP_RD, 8'h86, 32'h20},       // R3
    {4'd4,  OP_WR, 8'h28, 32'h80000002}, // R4
    {4'd4,  OP_RD, 8'h86, 32'h120},      // R4
    {4'd10, OP_WR, 8'h85, 32'hFFFFFFFF}, // R10
    {4'd10, OP_WR, 8'h86, 32'hFFFFFFFF}, // R10
    {4'd10, OP_RD, 8'h84, 32'h0},        // R10
    {4'd10, OP_RD, 8'h86, 32'h0},        // R10
    {4'd10, OP_RD, 8'h82, 32'h8},        // R10
    {4'd10, OP_IQ, 8'h00, 32'h0},        // R10
    {4'd2,  OP_WR, 8'h3F, 32'hDEADBEEF}, // R2
    {4'd2,  OP_RD, 8'h3F, 32'hDEADBEEF}, // R2
    {4'd2,  OP_RD, 8'h03, 32'h1}         // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_valid = 1'b0;
  logic [5:0]  inc_idx = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  syncpt_intr_ctrl i_syncpt_intr_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .inc_valid_i (inc_valid),
    .inc_idx_i   (inc_idx),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bump(input logic [5:0] n);
    @(negedge clk);
    inc_valid = 1'b1; inc_idx = n;
    @(negedge clk);
    inc_valid = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic iq(input string req, input logic [3:0] exp);
    @(negedge clk);
    #1;
    check(req, 32'(irq), 32'(exp));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1", 8'h03, 32'h0);
    rd("R1", 8'h3F, 32'h0);
    rd("R1", 8'h45, 32'h0);
    rd("R1", 8'h80, 32'h0);
    rd("R1", 8'h86, 32'h0);
    iq("R1", 4'h0);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[v][45:42]);
      case (VEC[v][41:40])
        OP_WR: wr(VEC[v][39:32], VEC[v][31:0]);
        OP_RD: rd(tag, VEC[v][39:32], VEC[v][31:0]);
        OP_IN: bump(VEC[v][37:32]);
        default: iq(tag, VEC[v][3:0]);
      endcase
    end

    // R9: increment event and status clear on syncpoint 1 in one cycle
    wr(8'h80, 32'h2);
    @(negedge clk);
    inc_valid = 1'b1; inc_idx = 6'd1;
    we = 1'b1; addr = 8'h82; wdata = 32'h2;
    @(negedge clk);
    inc_valid = 1'b0; we = 1'b0;
    rd("R9", 8'h82, 32'hA);
    iq("R9", 4'h1);
    wr(8'h82, 32'h2);
    rd("R6", 8'h82, 32'h8);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1", 8'h82, 32'h0);
    rd("R1", 8'h3F, 32'h0);
    rd("R1", 8'h43, 32'h0);
    iq("R1", 4'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule